// File: doc/BRIEF.md
# Serial EEPROM Slave Write Controller

This block is the write half of a two-wire serial EEPROM slave. A bus front end, which is not part of this block, already recovers START and STOP conditions and clocked bits. Those arrive here as single-cycle event pulses. The controller works through a fixed sequence: the device-select byte, two byte-address bytes, and then a burst of data bytes. Each data byte goes into a one-row page latch. On the acknowledge slot of every byte, the controller drives an acknowledge request. The front end turns that request into the low level on the data line.

A burst is committed only when STOP arrives in the slot right after an acknowledge clock, before any bit of the following byte. The commit starts an internal write cycle of a fixed, parameterised length. At the end of that cycle the latched bytes are copied into a behavioural memory array. For the whole cycle the slave ignores the bus and acknowledges nothing. A write-lock input makes the slave refuse data bytes. A combinational peek port on the array lets the surrounding read logic see the stored bytes.

Top module: `eeprom_wr_slave`

## Requirements
- R1: A byte received right after START is accepted only if its upper nibble is 4'b1010, bits [3:1] equal `chip_sel`, and bit 0 (direction) is 0. Such a byte is acknowledged. Any other byte is not acknowledged, and the slave ignores all later bytes until the next START.
- R2: After a matching select, the next two bytes form the byte address, high byte first. Both are acknowledged whatever the state of `wr_lock`. The working address is the low MEM_AW bits of the two bytes joined together.
- R3: While `wr_lock` is low, every data byte is acknowledged and stored in the page latch at the current address offset. One burst may carry from 1 to 64 bytes.
- R4: While `wr_lock` is high, a data byte is not acknowledged and is not latched. A burst made only of such bytes changes no memory location, and its STOP starts no write cycle.
- R5: After every data byte, only the low 6 bits of the address advance, so a burst wraps to the start of the same 64-byte row. When a burst writes the same address more than once, the last byte written to it is the one stored.
- R6: A STOP that arrives after an acknowledge clock, before any bit of the next byte, while in the data phase with at least one byte latched, starts the write cycle. `busy_o` is high from the clock edge that sees that STOP.
- R7: A STOP inside a byte, a STOP during an acknowledge slot, or a START in the middle of a burst throws away the latched bytes and writes nothing.
- R8: `busy_o` stays high for exactly TW_CYCLES clock cycles. The latched bytes appear on the peek port from the edge on which `busy_o` falls.
- R9: While `busy_o` is high, `ack_o` stays low for every byte, including the slave's own select code. Once the cycle ends, a new START is needed before anything is acknowledged.
- R10: A select byte whose direction bit is 1 (read) is not acknowledged by this block.
- R11: `ack_o` rises on the edge that takes in the 8th bit of an acknowledged byte, and it falls on the edge that takes in the 9th (acknowledge) clock.
- R12: After reset, `ack_o` and `busy_o` are low and every memory byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| stop_evt | input | 1 | One-cycle pulse: STOP seen on the bus |
| bit_evt | input | 1 | One-cycle pulse: a bus clock rose, `bit_val` is valid |
| bit_val | input | 1 | Data line value for this bit, MSB first |
| wr_lock | input | 1 | High: refuse and discard data bytes |
| chip_sel | input | 3 | Address bits this slave answers to in the select byte |
| rd_addr | input | MEM_AW | Peek address into the memory array |
| ack_o | output | 1 | High: pull the data line low in the acknowledge slot |
| busy_o | output | 1 | Internal write cycle in progress |
| rd_data | output | 8 | Memory byte at `rd_addr` (combinational) |

## Verification
The hardest case to reach is a STOP that falls exactly in the slot after the acknowledge clock, as opposed to one a single bit event earlier or later. The bench drives events as explicit pulses, so it can place STOP right after the 8th bit (an acknowledge slot), after the 9th clock (a commit), or a few bits into the next byte. It then checks `busy_o` and the whole array each time. Deafness during the write cycle is reached by sending a START and the slave's own select code within a few cycles of a commit, while the countdown is still running. A cycle-level behavioural model compares `ack_o` and `busy_o` on every clock.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_AHI,
        ST_ALO,
        ST_DATA,
        ST_BUSY
    } wr_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eewr_bit_rx.sv
module eewr_bit_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       bit_evt,
    input  logic       bit_val,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       ack_end,
    output logic       at_boundary
);

    typedef struct packed {
        logic [3:0] cnt;
        logic [6:0] sh;
        logic       bnd;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d         = q;
        byte_done = 1'b0;
        ack_end   = 1'b0;
        byte_val  = {q.sh, bit_val};
        if (start_evt || stop_evt) begin
            d.cnt = 4'd0;
            d.bnd = 1'b0;
        end else if (bit_evt) begin
            if (q.cnt == 4'd8) begin
                // clock of the acknowledge slot
                d.cnt   = 4'd0;
                d.bnd   = 1'b1;
                ack_end = 1'b1;
            end else begin
                d.bnd = 1'b0;
                d.sh  = {q.sh[5:0], bit_val};
                d.cnt = q.cnt + 4'd1;
                if (q.cnt == 4'd7) byte_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign at_boundary = q.bnd;

    // R11: the bit counter never passes the acknowledge slot
    a_r11_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= 4'd8);

    // R6: the commit window only opens after an acknowledge clock
    a_r6_bnd_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.bnd) |-> $past(bit_evt));

endmodule

// File: rtl/eewr_page_latch.sv
module eewr_page_latch #(
    parameter int PAGE_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [PAGE_W-1:0]         wr_idx,
    input  logic [7:0]                wr_data,
    output logic [(1<<PAGE_W)*8-1:0]  data_o,
    output logic [(1<<PAGE_W)-1:0]    valid_o,
    output logic                      any_valid
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q, valid_d;

    always_comb begin
        valid_d = valid_q;
        if (clr)        valid_d = '0;
        else if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    // later bytes to the same slot overwrite earlier ones
    always_ff @(posedge clk) begin
        if (wr_en && !clr) data_q[wr_idx] <= wr_data;
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_flat
        assign data_o[i*8 +: 8] = data_q[i];
    end

    assign valid_o   = valid_q;
    assign any_valid = |valid_q;

    // R7: a clear leaves nothing pending for the next commit
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);

endmodule

// File: rtl/eewr_mem_array.sv
module eewr_mem_array #(
    parameter int MEM_AW = 9,
    parameter int PAGE_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [MEM_AW-PAGE_W-1:0]    row,
    input  logic [(1<<PAGE_W)*8-1:0]    page_data,
    input  logic [(1<<PAGE_W)-1:0]      page_valid,
    input  logic [MEM_AW-1:0]           rd_addr,
    output logic [7:0]                  rd_data
);

    localparam int DEPTH      = 1 << MEM_AW;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= 8'h00;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (page_valid[i]) mem_q[{row, PAGE_W'(i)}] <= page_data[i*8 +: 8];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave #(
    parameter int MEM_AW    = 9,
    parameter int PAGE_W    = 6,
    parameter int TW_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_evt,
    input  logic              bit_val,
    input  logic              wr_lock,
    input  logic [2:0]        chip_sel,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic              ack_o,
    output logic              busy_o,
    output logic [7:0]        rd_data
);
    import eewr_pkg::*;

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = MEM_AW - PAGE_W;
    localparam int TMR_W      = $clog2(TW_CYCLES + 1);

    typedef struct packed {
        wr_state_e         state;
        logic [7:0]        hi;
        logic [MEM_AW-1:0] addr;
        logic [TMR_W-1:0]  timer;
        logic              ack;
    } ctl_t;

    ctl_t q, d;

    logic       byte_done, ack_end, at_bnd;
    logic [7:0] byte_val;
    logic       latch_clr, latch_wr, commit, any_valid;
    logic [PAGE_BYTES*8-1:0] page_data;
    logic [PAGE_BYTES-1:0]   page_valid;

    eewr_bit_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .bit_evt     (bit_evt),
        .bit_val     (bit_val),
        .byte_done   (byte_done),
        .byte_val    (byte_val),
        .ack_end     (ack_end),
        .at_boundary (at_bnd)
    );

    always_comb begin
        d         = q;
        latch_clr = 1'b0;
        latch_wr  = 1'b0;
        commit    = 1'b0;
        if (q.state == ST_BUSY) begin
            // deaf to the bus: only the countdown runs
            d.ack = 1'b0;
            if (q.timer == '0) begin
                commit    = 1'b1;
                latch_clr = 1'b1;
                d.state   = ST_IDLE;
            end else begin
                d.timer = q.timer - 1'b1;
            end
        end else if (start_evt) begin
            d.state   = ST_SEL;
            d.ack     = 1'b0;
            latch_clr = 1'b1;
        end else if (stop_evt) begin
            d.ack = 1'b0;
            if (q.state == ST_DATA && at_bnd && any_valid) begin
                d.state = ST_BUSY;
                d.timer = TMR_W'(TW_CYCLES - 1);
            end else begin
                d.state   = ST_IDLE;
                latch_clr = 1'b1;
            end
        end else begin
            if (ack_end) d.ack = 1'b0;
            if (byte_done) begin
                case (q.state)
                    ST_SEL: begin
                        if (byte_val[7:4] == DEV_TYPE && byte_val[3:1] == chip_sel
                            && !byte_val[0]) begin
                            d.ack   = 1'b1;
                            d.state = ST_AHI;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                    ST_AHI: begin
                        d.hi    = byte_val;
                        d.ack   = 1'b1;
                        d.state = ST_ALO;
                    end
                    ST_ALO: begin
                        d.addr  = MEM_AW'({q.hi, byte_val});
                        d.ack   = 1'b1;
                        d.state = ST_DATA;
                    end
                    ST_DATA: begin
                        if (!wr_lock) begin
                            latch_wr = 1'b1;
                            d.ack    = 1'b1;
                        end
                        d.addr[PAGE_W-1:0] = q.addr[PAGE_W-1:0] + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, hi: '0, addr: '0, timer: '0, ack: 1'b0};
        else        q <= d;
    end

    eewr_page_latch #(.PAGE_W(PAGE_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (latch_clr),
        .wr_en     (latch_wr),
        .wr_idx    (q.addr[PAGE_W-1:0]),
        .wr_data   (byte_val),
        .data_o    (page_data),
        .valid_o   (page_valid),
        .any_valid (any_valid)
    );

    eewr_mem_array #(.MEM_AW(MEM_AW), .PAGE_W(PAGE_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .row        (q.addr[MEM_AW-1:PAGE_W]),
        .page_data  (page_data),
        .page_valid (page_valid),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    assign ack_o  = q.ack;
    assign busy_o = (q.state == ST_BUSY);

    // R9: nothing is acknowledged during the write cycle
    a_r9_deaf_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ack_o);

    // R6: a write cycle only ever begins on a STOP
    a_r6_start_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_evt));

    // R11: the acknowledge clock releases the line
    a_r11_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && bit_evt) |=> !ack_o);

    // R4: a locked data byte is refused
    a_r4_lock_noack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DATA && byte_done && wr_lock && !start_evt && !stop_evt) |=> !ack_o);

    // R8: the write cycle lasts more than one edge
    if (TW_CYCLES > 1) begin : g_hold
        a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_o) |=> busy_o);
    end

    // R5: the row stays put while data bytes flow
    a_r5_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DATA && $past(q.state) == ST_DATA) |-> $stable(q.addr[MEM_AW-1:PAGE_W]));

    logic unused_row_w;
    assign unused_row_w = (ROW_W > 0);

endmodule

// File: tb/eeprom_wr_slave_bench.sv
module eeprom_wr_slave_bench;

    localparam int MEM_AW = 9;
    localparam int TW     = 40;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam logic [2:0] CS = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_evt = 1'b0, stop_evt = 1'b0, bit_evt = 1'b0, bit_val = 1'b0;
    logic wr_lock = 1'b0;
    logic [MEM_AW-1:0] rd_addr = '0;
    logic ack_o, busy_o;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    eeprom_wr_slave #(.MEM_AW(MEM_AW), .PAGE_W(6), .TW_CYCLES(TW)) u_eeprom_wr_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .bit_evt   (bit_evt),
        .bit_val   (bit_val),
        .wr_lock   (wr_lock),
        .chip_sel  (CS),
        .rd_addr   (rd_addr),
        .ack_o     (ack_o),
        .busy_o    (busy_o),
        .rd_data   (rd_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_phase;   // 0 idle, 1 select, 2 addr hi, 3 addr lo, 4 data
    int  m_bits, m_sh, m_hi, m_addr, m_left;
    bit  m_bnd, exp_ack;
    int  m_page [64];
    int  m_mem  [DEPTH];

    task automatic clear_page();
        for (int i = 0; i < 64; i++) m_page[i] = -1;
    endtask

    function automatic bit page_any();
        for (int i = 0; i < 64; i++) if (m_page[i] >= 0) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_bits = 0; m_sh = 0; m_hi = 0; m_addr = 0; m_left = 0;
            m_bnd = 0; exp_ack = 0;
            clear_page();
            for (int a = 0; a < DEPTH; a++) m_mem[a] = 0;
        end else if (m_left > 0) begin
            exp_ack = 0;
            m_left--;
            if (m_left == 0) begin
                for (int i = 0; i < 64; i++)
                    if (m_page[i] >= 0) m_mem[(m_addr / 64) * 64 + i] = m_page[i];
                clear_page();
                m_phase = 0;
            end
        end else if (start_evt) begin
            m_phase = 1; m_bits = 0; m_bnd = 0; exp_ack = 0;
            clear_page();
        end else if (stop_evt) begin
            exp_ack = 0;
            if (m_phase == 4 && m_bnd && page_any()) begin
                m_left = TW;
            end else begin
                m_phase = 0;
                clear_page();
            end
            m_bits = 0; m_bnd = 0;
        end else if (bit_evt) begin
            if (m_bits == 8) begin
                m_bits = 0; m_bnd = 1; exp_ack = 0;
            end else begin
                m_bnd = 0;
                m_sh  = ((m_sh << 1) | int'(bit_val)) & 255;
                m_bits++;
                if (m_bits == 8) begin
                    if (m_phase == 1) begin
                        if ((m_sh >> 4) == 10 && ((m_sh >> 1) & 7) == int'(CS) && (m_sh & 1) == 0) begin
                            exp_ack = 1; m_phase = 2;
                        end else m_phase = 0;
                    end else if (m_phase == 2) begin
                        m_hi = m_sh; exp_ack = 1; m_phase = 3;
                    end else if (m_phase == 3) begin
                        m_addr = ((m_hi << 8) | m_sh) % DEPTH; exp_ack = 1; m_phase = 4;
                    end else if (m_phase == 4) begin
                        if (!wr_lock) begin
                            m_page[m_addr % 64] = m_sh; exp_ack = 1;
                        end
                        m_addr = (m_addr / 64) * 64 + ((m_addr % 64) + 1) % 64;
                    end
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(ack_o == exp_ack, "R11 ack_o vs model", ack_o, exp_ack);
            chk(busy_o == (m_left > 0), "R8 busy_o vs model", busy_o, (m_left > 0));
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse_bit(input bit b);
        @(negedge clk); bit_evt = 1'b1; bit_val = b;
        @(negedge clk); bit_evt = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) pulse_bit(v[i]);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        send_bits(v, 8);
        acked = ack_o;
        pulse_bit(1'b1);
    endtask

    task automatic do_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < TW + 10 && busy_o; i++) @(negedge clk);
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); rd_addr = MEM_AW'(a);
            #1;
            if (rd_data != m_mem[a][7:0]) begin
                bad++;
                if (bad <= 4) chk(1'b0, tag, rd_data, m_mem[a]);
            end
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    // start, select, two address bytes; returns select/address acks
    task automatic open_write(input int addr, input string tag);
        bit a0, a1, a2;
        do_start();
        send_byte({4'b1010, CS, 1'b0}, a0);
        send_byte(8'((addr >> 8) & 255), a1);
        send_byte(8'(addr & 255), a2);
        chk(a0, {tag, " R1 own select acked"}, a0, 1);
        chk(a1 && a2, {tag, " R2 address acked"}, {a1, a2}, 3);
    endtask

    initial begin
        bit a;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(ack_o == 1'b0, "R12 ack_o in reset", ack_o, 0);
        chk(busy_o == 1'b0, "R12 busy_o in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        check_mem("R12 memory cleared");

        // single byte write: R3, R6, R8
        open_write(16'h0005, "single");
        send_byte(8'h5A, a);
        chk(a, "R3 data byte acked", a, 1);
        do_stop();
        chk(busy_o, "R6 busy after STOP in tenth slot", busy_o, 1);
        repeat (TW - 1) @(negedge clk);
        chk(busy_o, "R8 busy held TW cycles", busy_o, 1);
        @(negedge clk);
        chk(!busy_o, "R8 busy falls after TW", busy_o, 0);
        check_mem("R8 single byte in memory");

        // page wrap inside a row: R5
        open_write(16'h013E, "wrap");
        for (int i = 0; i < 4; i++) send_byte(8'(8'hC0 + i), a);
        do_stop();
        wait_idle();
        check_mem("R5 row wrap");

        // more than a row: last write wins, R5
        open_write(16'h0040, "over");
        for (int i = 0; i < 66; i++) send_byte(8'(i * 3 + 1), a);
        do_stop();
        wait_idle();
        check_mem("R5 last byte wins");

        // write lock: R4
        wr_lock = 1'b1;
        open_write(16'h0080, "lock");
        for (int i = 0; i < 3; i++) begin
            send_byte(8'hEE, a);
            chk(!a, "R4 locked byte not acked", a, 0);
        end
        do_stop();
        chk(!busy_o, "R4 no write cycle when locked", busy_o, 0);
        wr_lock = 1'b0;
        check_mem("R4 memory untouched");

        // STOP inside a byte: R7
        open_write(16'h00C0, "midbyte");
        send_byte(8'h11, a); send_byte(8'h22, a);
        send_bits(8'h33, 3);
        do_stop();
        chk(!busy_o, "R7 STOP mid byte no write", busy_o, 0);
        check_mem("R7 mid byte discarded");

        // STOP in the acknowledge slot: R7, R11
        open_write(16'h00D0, "ackslot");
        send_byte(8'h44, a); send_byte(8'h55, a);
        send_bits(8'h66, 8);
        chk(ack_o, "R11 ack high in slot", ack_o, 1);
        do_stop();
        chk(!busy_o, "R7 STOP in ack slot no write", busy_o, 0);
        chk(!ack_o, "R11 ack cleared by STOP", ack_o, 0);
        check_mem("R7 ack slot discarded");

        // repeated START mid burst, then a read select: R7, R10
        open_write(16'h00E0, "restart");
        send_byte(8'h77, a);
        do_start();
        send_byte({4'b1010, CS, 1'b1}, a);
        chk(!a, "R10 read select not acked", a, 0);
        do_stop();
        chk(!busy_o, "R7 restart discards", busy_o, 0);
        check_mem("R7 restart nothing written");

        // busy deafness: R9
        open_write(16'h0101, "busy");
        send_byte(8'h9C, a);
        do_stop();
        do_start();
        send_byte({4'b1010, CS, 1'b0}, a);
        chk(!a, "R9 own select ignored while busy", a, 0);
        chk(busy_o, "R9 still busy during probe", busy_o, 1);
        wait_idle();
        send_byte({4'b1010, CS, 1'b0}, a);
        chk(!a, "R9 no ack without new START", a, 0);
        do_stop();
        check_mem("R9 only first write landed");

        // foreign chip address: R1
        do_start();
        send_byte({4'b1010, 3'b011, 1'b0}, a);
        chk(!a, "R1 foreign select not acked", a, 0);
        send_byte(8'h00, a);
        chk(!a, "R1 later bytes ignored", a, 0);
        send_byte(8'h10, a);
        send_byte(8'hAB, a);
        do_stop();
        chk(!busy_o, "R1 no write after mismatch", busy_o, 0);
        check_mem("R1 memory untouched");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule